// File: doc/BRIEF.md
# Dual-Width Carry and Overflow Adder

This unit is the add/subtract datapath of a 64-bit integer core that can run either in full-width mode or in a 32-bit compatibility mode. It takes two operands and an operation code. It forms the sum in a single carry chain. From the carries at two word boundaries it derives two sets of flags. One set depends on the mode: CA and OV. The other set always describes the low word: CA32 and OV32.

The flags live in a small register inside the unit, together with a sticky summary-overflow bit. The extended operations read the stored carry back as their carry-in. This lets software chain multi-word arithmetic. The result output is combinational. The flags change on the clock edge that retires the operation.

Top module: `dual_carry_adder`

## Requirements
- R1: The result is X + Y + Cin modulo 2^XLEN. The operation code selects the terms as follows. 0 is add: A, B, 0. 1 is extended add: A, B, CA. 2 is subtract-from: ~A, B, 1. 3 is extended subtract-from: ~A, B, CA. 4 is add-minus-one: A, all-ones, CA. 5 is add-zero: A, 0, CA. 6 is negate: ~A, 0, 1. 7 is reserved and gives a result of 0. CA here is the stored flag.
- R2: An accepted operation with a code from 0 to 5 loads CA on the next clock edge. In full mode (mode64=1) the value is the carry out of the top bit. In 32-bit mode (mode64=0) it is the carry out of bit HALF-1.
- R3: The same operations load CA32 with the carry out of bit HALF-1 in either mode.
- R4: An accepted operation (codes 0 to 6) with ov_en=1 loads OV with signed overflow. In full mode this is overflow of the whole result. In 32-bit mode it is overflow of the low HALF bits.
- R5: The same operations load OV32 with signed overflow of the low HALF bits in either mode.
- R6: The following leave every flag unchanged: op_valid=0, or code 7. Negate leaves CA and CA32 unchanged.
- R7: An accepted operation with ov_en=0 leaves OV, OV32 and SO unchanged.
- R8: SO is set whenever R4 records an overflow. Otherwise SO keeps its value until so_clear is asserted. If so_clear arrives in the same cycle as a recorded overflow, SO still ends up set.
- R9: While rst_n is low, all five flags read 0.
- R10: Negate with ov_en=1 sets OV in the following cases. In full mode, when A is only the top bit set. In 32-bit mode, when the low word of A is only bit HALF-1 set. OV32 follows the low-word case in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_valid | input | 1 | An operation retires this cycle |
| op_sel | input | 3 | Operation code (see R1) |
| mode64 | input | 1 | 1 selects full-width flags, 0 selects 32-bit mode |
| ov_en | input | 1 | Record overflow for this operation |
| so_clear | input | 1 | Clear the sticky summary-overflow bit |
| opa | input | XLEN | Operand A |
| opb | input | XLEN | Operand B |
| result | output | XLEN | Sum, combinational |
| ca | output | 1 | Mode-dependent carry flag |
| ca32 | output | 1 | Low-word carry flag |
| ov | output | 1 | Mode-dependent overflow flag |
| ov32 | output | 1 | Low-word overflow flag |
| so | output | 1 | Sticky summary overflow |

## Verification
The bench builds the unit at eight bits with a four-bit low word. It runs every value of A against a fixed set of B values for every operation code in both modes. The B values include zero, all-ones, and both signed extremes of each width. These separate carry out of the low word from carry out of the top: an operand like 0x08 overflows the low word but not the whole, and 0x80 does the opposite. Along the sweep, op_valid, ov_en and so_clear are toggled in patterns that do not line up with the operation order. This checks that held flags really hold, and that the sticky bit survives and clears only as required. Directed negations of the most negative values at both widths finish the run.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADDE  = 3'd1,
    OP_SUBF  = 3'd2,
    OP_SUBFE = 3'd3,
    OP_ADDM1 = 3'd4,
    OP_ADDZ  = 3'd5,
    OP_NEG   = 3'd6,
    OP_NONE  = 3'd7
  } dwc_op_e;

  typedef struct packed {
    logic so;
    logic ov;
    logic ov32;
    logic ca;
    logic ca32;
  } dwc_flags_t;

  // signed overflow of a width: carry into its sign bit differs from carry out
  function automatic logic signed_ovf(input logic c_into_sign, input logic c_out_sign);
    return c_into_sign ^ c_out_sign;
  endfunction

  function automatic logic op_writes_carry(input dwc_op_e op);
    return (op != OP_NEG) && (op != OP_NONE);
  endfunction

  function automatic logic op_is_live(input dwc_op_e op);
    return op != OP_NONE;
  endfunction

endpackage

// File: rtl/dwc_operand.sv
module dwc_operand
  import dwc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  dwc_op_e           op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  input  logic              ca_cur,
  output logic [XLEN-1:0]   x,
  output logic [XLEN-1:0]   y,
  output logic              cin
);

  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    unique case (op)
      OP_ADD:   begin x = a;  y = b;          cin = 1'b0;   end
      OP_ADDE:  begin x = a;  y = b;          cin = ca_cur; end
      OP_SUBF:  begin x = ~a; y = b;          cin = 1'b1;   end
      OP_SUBFE: begin x = ~a; y = b;          cin = ca_cur; end
      OP_ADDM1: begin x = a;  y = '1;         cin = ca_cur; end
      OP_ADDZ:  begin x = a;  y = '0;         cin = ca_cur; end
      OP_NEG:   begin x = ~a; y = '0;         cin = 1'b1;   end
      default:  begin x = '0; y = '0;         cin = 1'b0;   end
    endcase
  end

endmodule

// File: rtl/dwc_carry_chain.sv
module dwc_carry_chain #(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic [XLEN-1:0] x,
  input  logic [XLEN-1:0] y,
  input  logic            cin,
  output logic [XLEN-1:0] sum,
  output logic            c_into_lsign,
  output logic            c_low_out,
  output logic            c_into_tsign,
  output logic            c_top_out
);

  localparam int NSEG = 4;
  localparam int BND [NSEG+1] = '{0, HALF-1, HALF, XLEN-1, XLEN};

  logic [NSEG:0] carry;
  assign carry[0] = cin;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam int LO = BND[k];
    localparam int HI = BND[k+1];
    localparam int W  = HI - LO;
    logic [W:0] part;
    assign part = {1'b0, x[HI-1:LO]} + {1'b0, y[HI-1:LO]} + {{W{1'b0}}, carry[k]};
    assign sum[HI-1:LO] = part[W-1:0];
    assign carry[k+1]   = part[W];
  end

  assign c_into_lsign = carry[1];
  assign c_low_out    = carry[2];
  assign c_into_tsign = carry[3];
  assign c_top_out    = carry[4];

  // a zero low word with zero carry-in cannot carry out of the low word
  always_comb begin
    if ((x[HALF-1:0] == '0) && (y[HALF-1:0] == '0) && !cin)
      AST_LOW_NO_CARRY: assert (!c_low_out && !c_into_lsign); // R3
  end

endmodule

// File: rtl/dwc_flag_reg.sv
module dwc_flag_reg
  import dwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_carry,
  input  logic       upd_ovf,
  input  logic       so_clear,
  input  logic       ca_n,
  input  logic       ca32_n,
  input  logic       ov_n,
  input  logic       ov32_n,
  output dwc_flags_t flags
);

  dwc_flags_t nxt;

  always_comb begin
    nxt = flags;
    if (upd_carry) begin
      nxt.ca   = ca_n;
      nxt.ca32 = ca32_n;
    end
    if (upd_ovf) begin
      nxt.ov   = ov_n;
      nxt.ov32 = ov32_n;
    end
    nxt.so = (flags.so && !so_clear) || (upd_ovf && ov_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

  AST_OV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_ovf |=> $stable(flags.ov) && $stable(flags.ov32)); // R7

  AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags.so && !so_clear |=> flags.so); // R8

  AST_SO_WITH_OV: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ovf && ov_n |=> flags.so && flags.ov); // R8

  AST_CARRY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_carry |=> $stable(flags.ca) && $stable(flags.ca32)); // R6

endmodule

// File: rtl/dual_carry_adder.sv
module dual_carry_adder
  import dwc_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_sel,
  input  logic            mode64,
  input  logic            ov_en,
  input  logic            so_clear,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic [XLEN-1:0] result,
  output logic            ca,
  output logic            ca32,
  output logic            ov,
  output logic            ov32,
  output logic            so
);

  dwc_op_e         op;
  dwc_flags_t      flags;
  logic [XLEN-1:0] x, y;
  logic            cin;
  logic            c_into_lsign, c_low_out, c_into_tsign, c_top_out;
  logic            ovf_low, ovf_full, ovf_mode, ca_mode;
  logic            live, upd_carry, upd_ovf;

  assign op = dwc_op_e'(op_sel);

  dwc_operand #(.XLEN(XLEN)) u_operand (
    .op     (op),
    .a      (opa),
    .b      (opb),
    .ca_cur (flags.ca),
    .x      (x),
    .y      (y),
    .cin    (cin)
  );

  dwc_carry_chain #(.XLEN(XLEN), .HALF(HALF)) u_chain (
    .x            (x),
    .y            (y),
    .cin          (cin),
    .sum          (result),
    .c_into_lsign (c_into_lsign),
    .c_low_out    (c_low_out),
    .c_into_tsign (c_into_tsign),
    .c_top_out    (c_top_out)
  );

  assign ovf_low   = signed_ovf(c_into_lsign, c_low_out);
  assign ovf_full  = signed_ovf(c_into_tsign, c_top_out);
  assign ovf_mode  = mode64 ? ovf_full : ovf_low;
  assign ca_mode   = mode64 ? c_top_out : c_low_out;

  assign live      = op_valid && op_is_live(op);
  assign upd_carry = live && op_writes_carry(op);
  assign upd_ovf   = live && ov_en;

  dwc_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_carry (upd_carry),
    .upd_ovf   (upd_ovf),
    .so_clear  (so_clear),
    .ca_n      (ca_mode),
    .ca32_n    (c_low_out),
    .ov_n      (ovf_mode),
    .ov32_n    (ovf_low),
    .flags     (flags)
  );

  assign ca   = flags.ca;
  assign ca32 = flags.ca32;
  assign ov   = flags.ov;
  assign ov32 = flags.ov32;
  assign so   = flags.so;

  AST_NARROW_CA_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    upd_carry && !mode64 |=> ca == ca32); // R2

  AST_NARROW_OV_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    upd_ovf && !mode64 |=> ov == ov32); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> $stable(ca) && $stable(ca32) && $stable(ov) && $stable(ov32)); // R6

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_NONE |-> result == '0); // R1

endmodule

// File: tb/dual_carry_adder_test.sv
`timescale 1ns/1ps
module dual_carry_adder_test;

  localparam int XL = 8;
  localparam int HF = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_sel = 3'd7;
  logic          mode64 = 1'b1;
  logic          ov_en = 1'b0;
  logic          so_clear = 1'b0;
  logic [XL-1:0] opa = '0;
  logic [XL-1:0] opb = '0;
  logic [XL-1:0] result;
  logic          ca, ca32, ov, ov32, so;

  logic m_ca = 1'b0, m_ca32 = 1'b0, m_ov = 1'b0, m_ov32 = 1'b0, m_so = 1'b0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  dual_carry_adder #(.XLEN(XL), .HALF(HF)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .mode64(mode64), .ov_en(ov_en), .so_clear(so_clear),
    .opa(opa), .opb(opb), .result(result),
    .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h mode64=%0b)",
               tag, act, exp, op_sel, opa, opb, mode64);
    end
  endtask

  function automatic logic [XL-1:0] pick_b(input int i);
    case (i)
      0: return 8'h00;  1: return 8'hFF;  2: return 8'h80;  3: return 8'h7F;
      4: return 8'h08;  5: return 8'hF7;  6: return 8'h01;  7: return 8'h0F;
      8: return 8'hF0;  9: return 8'h88; 10: return 8'h77; 11: return 8'h07;
      12: return 8'hF8; 13: return 8'h78; 14: return 8'h87; default: return 8'h5A;
    endcase
  endfunction

  task automatic apply(input logic [2:0] op, input logic [XL-1:0] a, input logic [XL-1:0] b,
                       input logic md, input logic oe, input logic clr, input logic vld);
    logic [XL-1:0] x, y, exp_res;
    logic          c;
    logic [XL:0]   fs;
    logic [HF:0]   ls;
    logic          ovf_f, ovf_l, live, wcar, wov;
    string         tc, to;
    @(negedge clk);
    op_sel = op; opa = a; opb = b; mode64 = md; ov_en = oe; so_clear = clr; op_valid = vld;
    case (op)
      3'd0: begin x = a;  y = b;   c = 1'b0; end
      3'd1: begin x = a;  y = b;   c = m_ca; end
      3'd2: begin x = ~a; y = b;   c = 1'b1; end
      3'd3: begin x = ~a; y = b;   c = m_ca; end
      3'd4: begin x = a;  y = '1;  c = m_ca; end
      3'd5: begin x = a;  y = '0;  c = m_ca; end
      3'd6: begin x = ~a; y = '0;  c = 1'b1; end
      default: begin x = '0; y = '0; c = 1'b0; end
    endcase
    fs = {1'b0, x} + {1'b0, y} + {{XL{1'b0}}, c};
    ls = {1'b0, x[HF-1:0]} + {1'b0, y[HF-1:0]} + {{HF{1'b0}}, c};
    exp_res = fs[XL-1:0];
    ovf_f = (x[XL-1] == y[XL-1]) && (fs[XL-1] != x[XL-1]);
    ovf_l = (x[HF-1] == y[HF-1]) && (fs[HF-1] != x[HF-1]);
    #1;
    chk(result == exp_res, "R1 result", 32'(result), 32'(exp_res));
    live = vld && (op != 3'd7);
    wcar = live && (op != 3'd6);
    wov  = live && oe;
    tc = wcar ? "R2" : "R6";
    to = wov ? "R4" : (live ? "R7" : "R6");
    if (wcar) begin m_ca = md ? fs[XL] : ls[HF]; m_ca32 = ls[HF]; end
    m_so = (m_so && !clr) || (wov && (md ? ovf_f : ovf_l));
    if (wov) begin m_ov = md ? ovf_f : ovf_l; m_ov32 = ovf_l; end
    @(posedge clk);
    #1;
    chk(ca   == m_ca,   {tc, " ca"},   32'(ca),   32'(m_ca));
    chk(ca32 == m_ca32, {(wcar ? "R3" : "R6"), " ca32"}, 32'(ca32), 32'(m_ca32));
    chk(ov   == m_ov,   {to, " ov"},   32'(ov),   32'(m_ov));
    chk(ov32 == m_ov32, {(wov ? "R5" : to), " ov32"}, 32'(ov32), 32'(m_ov32));
    chk(so   == m_so,   "R8 so",       32'(so),   32'(m_so));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired before the run ended");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk({ca, ca32, ov, ov32, so} == 5'b0, "R9 reset flags", 32'({ca, ca32, ov, ov32, so}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int md = 0; md < 2; md++)
      for (int op = 0; op < 8; op++)
        for (int a = 0; a < 256; a++)
          for (int bi = 0; bi < 16; bi++)
            apply(3'(op), 8'(a), pick_b(bi), 1'(md), 1'(a ^ bi),
                  (a[5:0] == 6'h2A) && (bi == 3), (a % 11) != 3);

    // negate of the most negative value at each width
    apply(3'd6, 8'h80, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1);
    chk(ov == 1'b1 && ov32 == 1'b0, "R10 neg full width", 32'({ov, ov32}), 32'b10);
    chk(so == 1'b1, "R8 overflow wins over clear", 32'(so), 32'd1);
    apply(3'd6, 8'h08, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
    chk(ov == 1'b1 && ov32 == 1'b1, "R10 neg low word narrow", 32'({ov, ov32}), 32'b11);
    apply(3'd6, 8'h08, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);
    chk(ov == 1'b0 && ov32 == 1'b1, "R10 neg low word full mode", 32'({ov, ov32}), 32'b01);
    apply(3'd0, 8'h01, 8'h01, 1'b1, 1'b0, 1'b1, 1'b1);
    chk(so == 1'b0, "R8 clear", 32'(so), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule